// File: doc/BRIEF.md
# Cell-Balancing Switch Sequencer

This block runs on the core clock and sequences a twelve-switch matrix that connects one cell of a series battery stack to a bidirectional converter. Eight cell switches pick the cell. Four polarity switches then tie it to the converter with the correct polarity. The block takes a four-bit command: the low three bits choose a cell, with zero meaning "open everything", and the top bit chooses charge or discharge. It handshakes with the converter controller through an enable output, a direction output, a direction echo input and a done input.

Every reconfiguration follows the same sequence. The converter is stopped first, and the direction echo is confirmed. Switches that are no longer needed are released together. The new switches are then closed one at a time, each after the previous one has finished slewing. Only then is the converter restarted. An open-all request ends in a low-power sleep state with the internal clock gated off. Two open-all requests in a row skip the whole sequence and force the matrix open at once.

Top module: `cell_balance_sequencer`

## Requirements
- R1: For a command whose low three bits hold n in 1..7, the settled cell switch vector has exactly bits n-1 and n set (cell_sw[0] is the bottom switch).
- R2: For such a command, the settled polarity vector pol_sw is 4'b1001 for odd n and 4'b0110 for even n. For n = 0, all twelve switches settle open.
- R3: For a non-zero cell command, conv_dir settles to the inverse of cmd_code[3]. No switch closes unless dir_echo differs from conv_dir (the inverted echo has been returned).
- R4: On an accepted command, conv_en is low in the next cycle. No switch changes while conv_en is high, and none changes until conv_done has been seen high.
- R5: Switches not needed by the new command open in a single cycle. Switches needed by both the old and the new command never open. Nothing closes until every opened switch reports slew_ok.
- R6: Needed switches close one per step in ascending index order: cell switches 0..7, then polarity switches 0..3 (vector index 8..11). Each step waits until the previous switch reports slew_ok.
- R7: After the last switch has closed, conv_en rises and stays high. The sequence ends when conv_done falls.
- R8: An open-all command ends with sleep high, clk_run low, conv_en low and every switch open.
- R9: An open-all request accepted right after another open-all request, with no cell command between them, opens all switches in the next cycle and also raises sleep and lowers clk_run in that cycle, without waiting for slew.
- R10: wait_code is one-hot or zero. Bit 0 means waiting for conv_done high, bit 1 the direction echo, bit 2 switch slew, bit 3 conv_done low. It is zero when idle or asleep.
- R11: abort_req is accepted as an open-all request and takes priority over a command in the same cycle. A command accepted while bias_ok is low is also treated as open-all.
- R12: Command 4'b1000 sets test_mode and leaves all switches open. Any other accepted request clears test_mode.
- R13: After reset: all switches open, conv_en low, sleep high, clk_run low, test_mode low, wait_code zero.
- R14: A new command accepted in the middle of a sequence restarts it from the enable-low step and settles to the new command's pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 4 | Bit 3 direction select, bits 2:0 cell number |
| bias_ok | input | 1 | Driver bias and charge supply good |
| abort_req | input | 1 | Fault abort, acts as an open-all request |
| slew_ok | input | 12 | Per-switch transition finished, index 0..7 cell, 8..11 polarity |
| conv_done | input | 1 | Converter current at rest (high) or running (low) |
| dir_echo | input | 1 | Inverted direction returned by the converter |
| cell_sw | output | 8 | Cell switch enables |
| pol_sw | output | 4 | Polarity switch enables |
| conv_en | output | 1 | Converter run enable |
| conv_dir | output | 1 | Converter direction, high for charge |
| sleep | output | 1 | Shutdown state flag |
| clk_run | output | 1 | Internal clock enable |
| test_mode | output | 1 | Test command in force |
| wait_code | output | 4 | Current wait condition, one-hot |

## Verification
On every cycle, the assertions check the following: at most one switch closes per cycle, the matrix is frozen while the converter is enabled, the sleep state keeps the matrix open and the clock gated, the status code is one-hot, and a back-to-back open-all opens the matrix in the next cycle. Some behaviours need the bench scenarios with modelled converter and slew delays. These are the ascending closing order, the wait on slew before each closure, the survival of switches shared between old and new command, the direction echo, and the settled pattern for every ordered pair of commands. The same applies to abort priority, the bias-low override and restart in the middle of a sequence.

// File: rtl/bal_pkg.sv
`timescale 1ns/1ps
package bal_pkg;
  typedef enum logic [2:0] {
    S_SHUT, S_EN_LOW, S_DIR, S_OFF_GO, S_OFF_WAIT, S_ON, S_EN_HI, S_ACTIVE
  } seq_state_e;

  localparam int WAIT_W    = 4;
  localparam int W_DONE_HI = 0;
  localparam int W_DIR     = 1;
  localparam int W_SLEW    = 2;
  localparam int W_DONE_LO = 3;
endpackage

// File: rtl/bal_cmd_decode.sv
`timescale 1ns/1ps
module bal_cmd_decode #(
  parameter int NCELL = 7,
  parameter int NPOL  = 4,
  localparam int CELLW = $clog2(NCELL + 1),
  localparam int NCSW  = NCELL + 1,
  localparam int NSW   = NCSW + NPOL
) (
  input  logic [CELLW-1:0] sel,
  output logic [NSW-1:0]   pattern
);
  logic any_cell;
  logic odd_cell;
  assign any_cell = (sel != '0);
  assign odd_cell = sel[0];

  // cell n closes the switches on both of its terminals
  for (genvar i = 0; i < NCSW; i++) begin : g_cell
    assign pattern[i] = any_cell && ((int'(sel) == i) || (int'(sel) == i + 1));
  end

  // odd cells use the outer polarity pair, even cells the inner ones
  for (genvar p = 0; p < NPOL; p++) begin : g_pol
    if (p == 0 || p == NPOL - 1) begin : g_outer
      assign pattern[NCSW+p] = any_cell && odd_cell;
    end else begin : g_inner
      assign pattern[NCSW+p] = any_cell && !odd_cell;
    end
  end
endmodule

// File: rtl/bal_seq_fsm.sv
`timescale 1ns/1ps
module bal_seq_fsm
  import bal_pkg::*;
#(
  parameter int NSW  = 12,
  parameter int CMDW = 4,
  localparam int IDXW = $clog2(NSW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMDW-1:0]   cmd_in,
  input  logic [NSW-1:0]    tgt_pat,
  input  logic              bias_ok,
  input  logic              abort_req,
  input  logic [NSW-1:0]    slew_ok,
  input  logic              conv_done,
  input  logic              dir_echo,
  output logic [NSW-1:0]    sw,
  output logic              conv_en,
  output logic              conv_dir,
  output logic              sleep,
  output logic              clk_run,
  output logic              test_mode,
  output logic [WAIT_W-1:0] wait_code
);
  localparam logic [CMDW-1:0] TEST_CODE = {1'b1, {(CMDW-1){1'b0}}};

  seq_state_e      state;
  logic [NSW-1:0]  tgt, off_mask;
  logic            pend, last_open, cmd_dir;
  logic [IDXW-1:0] pidx;

  logic            accept, open_req, hard_stop;
  logic [NSW-1:0]  need;
  logic            nxt_any;
  logic [IDXW-1:0] nxt_idx;

  assign accept    = cmd_valid || abort_req;
  assign open_req  = abort_req || !bias_ok || (cmd_in[CMDW-2:0] == '0);
  assign hard_stop = accept && open_req && last_open;
  assign need      = tgt & ~sw;

  // lowest-index switch still to be closed
  always_comb begin
    nxt_any = 1'b0;
    nxt_idx = '0;
    for (int i = NSW - 1; i >= 0; i--) begin
      if (need[i]) begin
        nxt_any = 1'b1;
        nxt_idx = IDXW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_SHUT;   sw <= '0;        tgt <= '0;      off_mask <= '0;
      pend <= 1'b0;      pidx <= '0;      conv_en <= 1'b0; conv_dir <= 1'b1;
      cmd_dir <= 1'b0;   sleep <= 1'b1;   clk_run <= 1'b0; test_mode <= 1'b0;
      last_open <= 1'b0;
    end else if (accept) begin
      last_open <= open_req;
      test_mode <= !abort_req && (cmd_in == TEST_CODE);
      cmd_dir   <= cmd_in[CMDW-1];
      tgt       <= open_req ? '0 : tgt_pat;
      pend      <= 1'b0;
      conv_en   <= 1'b0;
      if (hard_stop) begin
        sw      <= '0;
        state   <= S_SHUT;
        sleep   <= 1'b1;
        clk_run <= 1'b0;
      end else begin
        state   <= S_EN_LOW;
        sleep   <= 1'b0;
        clk_run <= 1'b1;
      end
    end else begin
      case (state)
        S_EN_LOW: if (conv_done) begin
          if (tgt != '0) begin
            conv_dir <= !cmd_dir;
            state    <= S_DIR;
          end else begin
            state    <= S_OFF_GO;
          end
        end
        S_DIR: if (dir_echo != conv_dir) state <= S_OFF_GO;
        S_OFF_GO: begin
          sw       <= sw & tgt;
          off_mask <= sw & ~tgt;
          state    <= S_OFF_WAIT;
        end
        S_OFF_WAIT: if ((slew_ok & off_mask) == off_mask) begin
          if (tgt == '0) begin
            state   <= S_SHUT;
            sleep   <= 1'b1;
            clk_run <= 1'b0;
          end else begin
            state   <= S_ON;
          end
        end
        S_ON: begin
          if (pend) begin
            if (slew_ok[pidx]) pend <= 1'b0;
          end else if (nxt_any) begin
            sw[nxt_idx] <= 1'b1;
            pidx        <= nxt_idx;
            pend        <= 1'b1;
          end else begin
            conv_en <= 1'b1;
            state   <= S_EN_HI;
          end
        end
        S_EN_HI: if (!conv_done) state <= S_ACTIVE;
        default: ;
      endcase
    end
  end

  always_comb begin
    wait_code            = '0;
    wait_code[W_DONE_HI] = (state == S_EN_LOW);
    wait_code[W_DIR]     = (state == S_DIR);
    wait_code[W_SLEW]    = (state == S_OFF_GO) || (state == S_OFF_WAIT) || (state == S_ON);
    wait_code[W_DONE_LO] = (state == S_EN_HI);
  end

  p_single_close_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(sw & ~$past(sw)) <= 1);

  p_frozen_when_running_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(conv_en) && conv_en) |-> $stable(sw));

  p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (sw == '0 && !conv_en && !clk_run));

  p_wait_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wait_code));

  p_double_open_r9: assert property (@(posedge clk) disable iff (rst)
    hard_stop |=> (sw == '0 && sleep && !clk_run));
endmodule

// File: rtl/cell_balance_sequencer.sv
`timescale 1ns/1ps
module cell_balance_sequencer
  import bal_pkg::*;
#(
  parameter int NCELL = 7,
  parameter int NPOL  = 4,
  localparam int CELLW = $clog2(NCELL + 1),
  localparam int CMDW  = CELLW + 1,
  localparam int NCSW  = NCELL + 1,
  localparam int NSW   = NCSW + NPOL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMDW-1:0]   cmd_code,
  input  logic              bias_ok,
  input  logic              abort_req,
  input  logic [NSW-1:0]    slew_ok,
  input  logic              conv_done,
  input  logic              dir_echo,
  output logic [NCSW-1:0]   cell_sw,
  output logic [NPOL-1:0]   pol_sw,
  output logic              conv_en,
  output logic              conv_dir,
  output logic              sleep,
  output logic              clk_run,
  output logic              test_mode,
  output logic [WAIT_W-1:0] wait_code
);
  logic [NSW-1:0] pattern;
  logic [NSW-1:0] sw;

  bal_cmd_decode #(.NCELL(NCELL), .NPOL(NPOL)) u_decode (
    .sel     (cmd_code[CELLW-1:0]),
    .pattern (pattern)
  );

  bal_seq_fsm #(.NSW(NSW), .CMDW(CMDW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_in    (cmd_code),
    .tgt_pat   (pattern),
    .bias_ok   (bias_ok),
    .abort_req (abort_req),
    .slew_ok   (slew_ok),
    .conv_done (conv_done),
    .dir_echo  (dir_echo),
    .sw        (sw),
    .conv_en   (conv_en),
    .conv_dir  (conv_dir),
    .sleep     (sleep),
    .clk_run   (clk_run),
    .test_mode (test_mode),
    .wait_code (wait_code)
  );

  assign cell_sw = sw[NCSW-1:0];
  assign pol_sw  = sw[NSW-1:NCSW];
endmodule

// File: tb/cell_balance_sequencer_bench.sv
`timescale 1ns/1ps
module cell_balance_sequencer_bench;
  localparam int NSW  = 12;
  localparam int RAMP = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst = 1'b1, cmd_valid = 1'b0, bias_ok = 1'b1, abort_req = 1'b0;
  logic [3:0]     cmd_code = '0;
  logic [NSW-1:0] slew_ok;
  logic           conv_done, dir_echo;
  logic [7:0]     cell_sw;
  logic [3:0]     pol_sw, wait_code;
  logic           conv_en, conv_dir, sleep, clk_run, test_mode;
  logic [NSW-1:0] sw_all;
  assign sw_all = {pol_sw, cell_sw};

  cell_balance_sequencer u_cell_balance_sequencer (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .bias_ok(bias_ok), .abort_req(abort_req), .slew_ok(slew_ok),
    .conv_done(conv_done), .dir_echo(dir_echo), .cell_sw(cell_sw),
    .pol_sw(pol_sw), .conv_en(conv_en), .conv_dir(conv_dir), .sleep(sleep),
    .clk_run(clk_run), .test_mode(test_mode), .wait_code(wait_code));

  // slew model: a switch reports done slew_n negedges after it changed
  int             slew_n = 2;
  logic [NSW-1:0] sw_prev = '0;
  int             slew_cnt [NSW] = '{default: 100};
  always @(negedge clk) begin
    sw_prev <= sw_all;
    for (int i = 0; i < NSW; i++) begin
      if (sw_all[i] !== sw_prev[i]) slew_cnt[i] <= 0;
      else if (slew_cnt[i] < slew_n) slew_cnt[i] <= slew_cnt[i] + 1;
    end
  end
  always_comb
    for (int i = 0; i < NSW; i++) slew_ok[i] = (sw_all[i] === sw_prev[i]) && (slew_cnt[i] >= slew_n);

  // converter model: done follows the inverse of enable after RAMP cycles
  logic done_r = 1'b1;
  int   ramp_cnt = 0;
  logic [1:0] dir_pipe = 2'b00;
  assign conv_done = done_r;
  assign dir_echo  = dir_pipe[1];
  always @(negedge clk) begin
    if (conv_en === done_r) begin
      if (ramp_cnt >= RAMP) begin done_r <= ~done_r; ramp_cnt <= 0; end
      else ramp_cnt <= ramp_cnt + 1;
    end else ramp_cnt <= 0;
    dir_pipe <= {dir_pipe[0], ~conv_dir};
  end

  int checks = 0, errors = 0;
  int tx_id = 0;
  logic [NSW-1:0] keep_mask = '0;
  logic [3:0] seen_wait;

  // monitor of ordering rules
  int mon_checks = 0, mon_errors = 0;
  initial begin
    logic [NSW-1:0] prev_sw, snap_slew, rise, fall;
    logic prev_en, snap_dirok;
    int seen_tx, last_rise, fall_cycles, idx;
    prev_sw = '0; prev_en = 1'b0; snap_slew = '1; snap_dirok = 1'b0;
    seen_tx = 0; last_rise = -1; fall_cycles = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (seen_tx != tx_id) begin seen_tx = tx_id; last_rise = -1; fall_cycles = 0; end
        rise = sw_all & ~prev_sw;
        fall = prev_sw & ~sw_all;
        if (rise != '0) begin
          idx = -1;
          for (int i = NSW - 1; i >= 0; i--) if (rise[i]) idx = i;
          mon_checks++;
          if ($countones(rise) != 1) begin mon_errors++; $display("FAIL R6 closes per cycle: got %0d expected 1", $countones(rise)); end
          if (idx <= last_rise) begin mon_errors++; $display("FAIL R6 order: closed %0d after %0d", idx, last_rise); end
          if (snap_slew != '1) begin mon_errors++; $display("FAIL R6 slew: slew_ok %h expected %h", snap_slew, {NSW{1'b1}}); end
          if (!snap_dirok) begin mon_errors++; $display("FAIL R3 echo: closed a switch with echo %b dir %b", dir_echo, conv_dir); end
          last_rise = idx;
        end
        if ((rise | fall) != '0) begin
          mon_checks++;
          if (prev_en) begin mon_errors++; $display("FAIL R4 change while enabled: sw %h expected %h", sw_all, prev_sw); end
        end
        if (fall != '0) begin
          fall_cycles++;
          mon_checks++;
          if (fall_cycles > 1) begin mon_errors++; $display("FAIL R5 open cycles: got %0d expected 1", fall_cycles); end
          if ((fall & keep_mask) != '0) begin mon_errors++; $display("FAIL R5 kept switch opened: %h expected 0", fall & keep_mask); end
        end
      end
      prev_sw = sw_all; prev_en = conv_en;
      #1;
      snap_slew = slew_ok; snap_dirok = (dir_echo != conv_dir);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: actual %0h expected %0h", req, act, exp); end
  endtask

  function automatic logic [NSW-1:0] exp_sw(input logic [3:0] c);
    logic [7:0] cs; logic [3:0] ps; int n;
    n  = int'(c[2:0]);
    cs = (n == 0) ? 8'h00 : 8'(3 << (n - 1));
    ps = (n == 0) ? 4'h0 : (c[0] ? 4'b1001 : 4'b0110);
    return {ps, cs};
  endfunction

  task automatic send(input logic [3:0] c, input logic [NSW-1:0] keep);
    @(negedge clk);
    keep_mask = keep; cmd_code = c; cmd_valid = 1'b1; tx_id++;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic settle();
    bit ok; ok = 0; seen_wait = '0;
    for (int i = 0; i < 3000; i++) begin
      if (!$onehot0(wait_code)) begin errors++; $display("FAIL R10 code: actual %h expected one-hot", wait_code); end
      seen_wait |= wait_code;
      if (wait_code == 4'b0000 && (sleep || conv_en)) begin ok = 1; break; end
      @(negedge clk);
    end
    chk(ok, "R7 settle", int'(wait_code), 0);
  endtask

  task automatic check_final(input logic [3:0] c);
    logic [NSW-1:0] e; e = exp_sw(c);
    chk(cell_sw == e[7:0], "R1 cell switches", cell_sw, e[7:0]);
    chk(pol_sw == e[11:8], "R2 polarity", pol_sw, e[11:8]);
    chk(test_mode == (c == 4'b1000), "R12 test mode", test_mode, c == 4'b1000);
    if (c[2:0] == 3'd0) begin
      chk(sleep && !clk_run && !conv_en, "R8 sleep", {sleep, clk_run, conv_en}, 3'b100);
    end else begin
      chk(conv_en && !sleep && clk_run, "R7 enabled", {sleep, clk_run, conv_en}, 3'b011);
      chk(conv_dir == !c[3], "R3 direction", conv_dir, !c[3]);
    end
  endtask

  initial begin
    logic [3:0] last;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk(sw_all == '0, "R13 switches", sw_all, 0);
    chk(!conv_en && sleep && !clk_run && !test_mode, "R13 flags",
        {conv_en, sleep, clk_run, test_mode}, 4'b0100);
    chk(wait_code == '0, "R13 wait", wait_code, 0);

    // R10: wake from sleep passes every wait condition
    send(4'b0101, '0);
    chk(wait_code == 4'b0001 && !conv_en, "R4 R10 enable-low step", {wait_code, conv_en}, 5'b00010);
    settle();
    chk(seen_wait == 4'b1111, "R10 all waits seen", seen_wait, 4'hf);
    check_final(4'b0101);

    // R4: leaving an active cell drops enable first
    send(4'b1110, exp_sw(4'b0101) & exp_sw(4'b1110));
    chk(wait_code == 4'b0001 && !conv_en, "R4 enable low", {wait_code, conv_en}, 5'b00010);
    settle();
    check_final(4'b1110);
    last = 4'b1110;

    // R1 R2 R3 R5 R12: all ordered command pairs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        slew_n = 1 + (b % 3);
        send(4'(a), exp_sw(last) & exp_sw(4'(a)));
        settle();
        send(4'(b), exp_sw(4'(a)) & exp_sw(4'(b)));
        settle();
        check_final(4'(b));
        last = 4'(b);
      end
    end

    // R9: back-to-back open-all with slow slew
    slew_n = 2;
    send(4'b0011, exp_sw(last) & exp_sw(4'b0011));
    settle();
    slew_n = 40;
    @(negedge clk);
    cmd_code = 4'b0000; cmd_valid = 1'b1; tx_id++; keep_mask = '0;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(sw_all == '0, "R9 matrix open", sw_all, 0);
    chk(sleep && !clk_run && !conv_en, "R9 sleep", {sleep, clk_run, conv_en}, 3'b100);
    slew_n = 2;
    repeat (50) @(negedge clk);

    // R11: abort wins over a same-cycle command
    send(4'b0011, '0);
    settle();
    @(negedge clk);
    cmd_code = 4'b0110; cmd_valid = 1'b1; abort_req = 1'b1; tx_id++; keep_mask = '0;
    @(negedge clk);
    cmd_valid = 1'b0; abort_req = 1'b0;
    settle();
    chk(sw_all == '0 && sleep, "R11 abort opens", sw_all, 0);
    chk(!test_mode, "R11 abort clears test", test_mode, 0);

    // R11: bias not good turns a cell command into open-all
    send(4'b0010, '0);
    settle();
    check_final(4'b0010);
    bias_ok = 1'b0;
    send(4'b0111, '0);
    settle();
    bias_ok = 1'b1;
    chk(sw_all == '0 && sleep, "R11 bias low", sw_all, 0);

    // R14: restart in the middle of a sequence
    send(4'b0001, '0);
    settle();
    send(4'b0110, '0);
    repeat (6) @(negedge clk);
    chk(wait_code != 4'b0000, "R14 mid sequence", wait_code, 1);
    send(4'b1011, '0);
    settle();
    check_final(4'b1011);

    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks, errors + mon_errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks + 1, errors + mon_errors + 1);
    $finish;
  end
endmodule